// File: doc/BRIEF.md
# Single-to-Dual Pixel Splitter

This block takes one pixel word per pixel clock from the input capture stage and hands words to two downstream frame serializers. In dual mode it pairs consecutive pixels. The first pixel of each pair is held in a register. When the second pixel arrives, both words are published together, so each channel advances at half the input rate. In single mode every pixel goes straight to channel A, and channel B stays at zero.

Pairing is anchored to the data-enable bit carried inside the pixel word. A rising edge of that bit must land on the first slot of a pair. Blanking periods with an even cycle count keep that true from line to line. If a rising edge lands on the second slot, the block raises a sticky alignment error. It then re-anchors the pairing on that pixel. The sleep input works as an active-low run control: holding it low clears the pairing state, the held pixel, the outputs and the error flag. Serialization is done elsewhere.

Top module: `pixel_pair_splitter`

## Requirements
- R1: `mode_dual` = 0 selects one-in/one-out operation and `mode_dual` = 1 selects one-in/two-out operation; `pair_vld` is asserted only when the previous edge saw `mode_dual` = 1.
- R2: In single mode, after each clock edge `chan_a` equals the word sampled at that edge, `chan_b` is all zeros, `frame_en` is 1 and `pair_vld` is 0.
- R3: In dual mode, the first word after restart or realignment is held. The word sampled at the next edge goes to `chan_b` and the held word goes to `chan_a`. Both become visible together after that edge.
- R4: In dual mode, `pair_vld` and `frame_en` are high for exactly one cycle per pair, on alternate cycles. `chan_a`/`chan_b` keep their values on the cycles between pairs.
- R5: The data-enable flag is bit `DE_POS` of the word (default 26). The whole 28-bit word, including the sync and enable bits, is carried unchanged to whichever channel receives it.
- R6: With even-length blanking and even-length active runs, a rising data-enable always falls on the first slot of a pair, and `align_err` stays 0.
- R7: A rising data-enable sampled while the second slot is expected sets `align_err`. That cycle publishes no pair, and the earlier held word is dropped. The rising-edge word becomes `chan_a` of the next pair.
- R8: Once set, `align_err` stays 1 while `wake` stays 1.
- R9: When `wake` is 0 at an edge, all outputs, the held word, the pair phase and `align_err` are cleared. After `wake` returns to 1, the first word sampled is treated as a first slot.
- R10: Synchronous active-high `rst` clears the same state as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_dual | input | 1 | 0: single channel, 1: two-channel pairing |
| wake | input | 1 | 1: running, 0: sleep (state cleared) |
| pix_in | input | 28 | Pixel word, data-enable at bit DE_POS |
| chan_a | output | 28 | Channel A word (odd pixel in dual mode) |
| chan_b | output | 28 | Channel B word (even pixel in dual mode) |
| pair_vld | output | 1 | One-cycle strobe when a pair is published |
| frame_en | output | 1 | Load enable for the serializers |
| align_err | output | 1 | Sticky pairing error flag |

## Verification
The bench sweeps several even blanking and active lengths in dual mode and checks every published pair against the stream index. A phase that ignored blanking or toggled wrongly would shift pixels between channels or strobe on the wrong cycle. It then forces an odd blanking run so that a rising data-enable hits the second slot. A design that did not realign would pair the stale held word, and one that did not latch the error would let the flag drop. Sleep and reset are applied mid-stream. Stale held data or a leftover phase after restart would show up in the first pair that follows.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    localparam int PXS_WORD_W = 28;
    localparam int PXS_DE_POS = 26;

    typedef enum logic {
        PXS_SINGLE = 1'b0,
        PXS_DUAL   = 1'b1
    } pxs_mode_e;

    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } pxs_slot_e;

    // Per-cycle steering decided by the phase controller
    typedef struct packed {
        logic run;     // awake and out of reset
        logic dual;    // pairing active
        logic take_a;  // capture word into the hold register
        logic emit;    // publish held word + current word
    } pxs_ctl_t;

    function automatic logic pxs_rise(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/pxs_de_edge.sv
module pxs_de_edge (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic de_in,
    output logic de_rise
);
    import pxs_pkg::*;

    logic de_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            de_q <= 1'b0;
        end else begin
            de_q <= de_in;
        end
    end

    assign de_rise = pxs_rise(de_in, de_q);

endmodule

// File: rtl/pxs_phase_ctl.sv
module pxs_phase_ctl (
    input  logic                clk,
    input  logic                rst,
    input  logic                wake,
    input  pxs_pkg::pxs_mode_e  mode,
    input  logic                de_rise,
    output pxs_pkg::pxs_ctl_t   ctl,
    output logic                err
);
    import pxs_pkg::*;

    pxs_slot_e slot_q;
    logic      err_q;
    logic      misalign;

    always_comb begin
        misalign   = (mode == PXS_DUAL) && de_rise && (slot_q == SLOT_B);
        ctl.run    = wake && !rst;
        ctl.dual   = (mode == PXS_DUAL);
        ctl.take_a = ctl.dual && ((slot_q == SLOT_A) || misalign);
        ctl.emit   = ctl.dual && (slot_q == SLOT_B) && !misalign;
    end

    always_ff @(posedge clk) begin
        if (rst || !wake) begin
            slot_q <= SLOT_A;
            err_q  <= 1'b0;
        end else if (mode == PXS_SINGLE) begin
            slot_q <= SLOT_A;
        end else begin
            slot_q <= ctl.take_a ? SLOT_B : SLOT_A;
            if (misalign) begin
                err_q <= 1'b1;
            end
        end
    end

    assign err = err_q;

endmodule

// File: rtl/pxs_pair_regs.sv
module pxs_pair_regs #(
    parameter int WORD_W = pxs_pkg::PXS_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  pxs_pkg::pxs_ctl_t ctl,
    input  logic [WORD_W-1:0] pix_in,
    output logic [WORD_W-1:0] chan_a,
    output logic [WORD_W-1:0] chan_b,
    output logic              pair_vld,
    output logic              frame_en
);
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] a_q;
    logic [WORD_W-1:0] b_q;
    logic              vld_q;
    logic              fen_q;

    always_ff @(posedge clk) begin
        if (rst || !ctl.run) begin
            hold_q <= '0;
            a_q    <= '0;
            b_q    <= '0;
            vld_q  <= 1'b0;
            fen_q  <= 1'b0;
        end else if (!ctl.dual) begin
            hold_q <= '0;
            a_q    <= pix_in;
            b_q    <= '0;
            vld_q  <= 1'b0;
            fen_q  <= 1'b1;
        end else begin
            vld_q <= ctl.emit;
            fen_q <= ctl.emit;
            if (ctl.take_a) begin
                hold_q <= pix_in;
            end
            if (ctl.emit) begin
                a_q <= hold_q;
                b_q <= pix_in;
            end
        end
    end

    assign chan_a   = a_q;
    assign chan_b   = b_q;
    assign pair_vld = vld_q;
    assign frame_en = fen_q;

endmodule

// File: rtl/pixel_pair_splitter.sv
module pixel_pair_splitter #(
    parameter int WORD_W = pxs_pkg::PXS_WORD_W,
    parameter int DE_POS = pxs_pkg::PXS_DE_POS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_dual,
    input  logic              wake,
    input  logic [WORD_W-1:0] pix_in,
    output logic [WORD_W-1:0] chan_a,
    output logic [WORD_W-1:0] chan_b,
    output logic              pair_vld,
    output logic              frame_en,
    output logic              align_err
);
    import pxs_pkg::*;

    localparam int DE_IDX = (DE_POS < WORD_W) ? DE_POS : WORD_W - 1;

    pxs_mode_e mode;
    pxs_ctl_t  ctl;
    logic      de_rise;

    assign mode = mode_dual ? PXS_DUAL : PXS_SINGLE;

    pxs_de_edge u_de_edge (
        .clk     (clk),
        .rst     (rst),
        .clr     (!wake),
        .de_in   (pix_in[DE_IDX]),
        .de_rise (de_rise)
    );

    pxs_phase_ctl u_phase (
        .clk     (clk),
        .rst     (rst),
        .wake    (wake),
        .mode    (mode),
        .de_rise (de_rise),
        .ctl     (ctl),
        .err     (align_err)
    );

    pxs_pair_regs #(.WORD_W(WORD_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .pix_in   (pix_in),
        .chan_a   (chan_a),
        .chan_b   (chan_b),
        .pair_vld (pair_vld),
        .frame_en (frame_en)
    );

endmodule

// File: rtl/pixel_pair_splitter_chk.sv
module pixel_pair_splitter_chk #(
    parameter int WORD_W = 28,
    parameter int DE_POS = 26
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_dual,
    input logic              wake,
    input logic [WORD_W-1:0] pix_in,
    input logic [WORD_W-1:0] chan_a,
    input logic [WORD_W-1:0] chan_b,
    input logic              pair_vld,
    input logic              frame_en,
    input logic              align_err
);
    assert_pair_needs_dual_R1: assert property (@(posedge clk) disable iff (rst)
        pair_vld |-> $past(mode_dual));

    assert_single_b_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_en && !pair_vld) |-> (chan_b == '0));

    assert_b_takes_last_word_R3: assert property (@(posedge clk) disable iff (rst)
        pair_vld |-> (chan_b == $past(pix_in)));

    assert_pair_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        pair_vld |=> !pair_vld);

    assert_err_on_de_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(align_err) |-> $past(pix_in[DE_POS]));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(align_err) && $past(wake) && !$past(rst)) |-> align_err);

    assert_sleep_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(wake) |-> (!pair_vld && !frame_en && !align_err
                          && chan_a == '0 && chan_b == '0));

endmodule

bind pixel_pair_splitter pixel_pair_splitter_chk #(
    .WORD_W (WORD_W),
    .DE_POS (DE_POS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_dual (mode_dual),
    .wake      (wake),
    .pix_in    (pix_in),
    .chan_a    (chan_a),
    .chan_b    (chan_b),
    .pair_vld  (pair_vld),
    .frame_en  (frame_en),
    .align_err (align_err)
);

// File: tb/pixel_pair_splitter_bench.sv
module pixel_pair_splitter_bench;

    localparam int CLK_P = 10;
    localparam int W     = 28;
    localparam int DE    = 26;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_dual = 1'b0;
    logic         wake = 1'b0;
    logic [W-1:0] pix_in = '0;
    logic [W-1:0] chan_a;
    logic [W-1:0] chan_b;
    logic         pair_vld;
    logic         frame_en;
    logic         align_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // dual-mode bookkeeping from the requirements
    int           t_idx = 0;
    int           g_idx = 0;
    logic [W-1:0] prev_w = '0;
    logic [W-1:0] ea = '0;
    logic [W-1:0] eb = '0;

    always #(CLK_P/2) clk = ~clk;

    pixel_pair_splitter #(.WORD_W(W), .DE_POS(DE)) u_pixel_pair_splitter (
        .clk       (clk),
        .rst       (rst),
        .mode_dual (mode_dual),
        .wake      (wake),
        .pix_in    (pix_in),
        .chan_a    (chan_a),
        .chan_b    (chan_b),
        .pair_vld  (pair_vld),
        .frame_en  (frame_en),
        .align_err (align_err)
    );

    function automatic logic [W-1:0] pv(input int idx, input logic de);
        logic [W-1:0] v;
        v = W'(idx * 40503 + 81);
        v[DE] = de;
        return v;
    endfunction

    task automatic chkw(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chkb(input string req, input string what,
                        input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] px);
        @(negedge clk);
        pix_in = px;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_clear(input string req);
        chkw(req, "chan_a", chan_a, '0);
        chkw(req, "chan_b", chan_b, '0);
        chkb(req, "pair_vld", pair_vld, 1'b0);
        chkb(req, "frame_en", frame_en, 1'b0);
        chkb(req, "align_err", align_err, 1'b0);
    endtask

    // one dual-mode word; realign marks a rising DE on the second slot
    task automatic dual_step(input logic [W-1:0] cur, input logic exp_err,
                             input logic realign, input string req);
        logic exp_pair;
        drive(cur);
        if (realign) begin
            exp_pair = 1'b0;
            t_idx = 0;
        end else if (t_idx % 2 == 1) begin
            exp_pair = 1'b1;
            ea = prev_w;
            eb = cur;
        end else begin
            exp_pair = 1'b0;
        end
        chkb(req, "pair_vld", pair_vld, exp_pair);
        chkb(req, "frame_en", frame_en, exp_pair);
        chkw(req, "chan_a", chan_a, ea);
        chkw(req, "chan_b", chan_b, eb);
        chkb(req, "align_err", align_err, exp_err);
        prev_w = cur;
        t_idx++;
        g_idx++;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) drive('0);
        chk_clear("R10");

        // R1, R2, R5: single mode passes each word to channel A
        rst = 1'b0;
        wake = 1'b1;
        mode_dual = 1'b0;
        for (int i = 0; i < 24; i++) begin
            logic [W-1:0] w;
            w = pv(g_idx, (i % 5) > 1);
            drive(w);
            chkw("R2", "chan_a", chan_a, w);
            chkw("R5", "chan_a DE bit", {27'b0, chan_a[DE]}, {27'b0, w[DE]});
            chkw("R2", "chan_b", chan_b, '0);
            chkb("R2", "frame_en", frame_en, 1'b1);
            chkb("R1", "pair_vld single", pair_vld, 1'b0);
            g_idx++;
        end

        // R9: sleep clears, then restart in dual mode
        wake = 1'b0;
        drive(pv(g_idx, 1'b1));
        chk_clear("R9");
        wake = 1'b1;
        mode_dual = 1'b1;
        t_idx = 0; ea = '0; eb = '0;

        // R3, R4, R5, R6: sweep even blanking and active lengths
        for (int b = 2; b <= 6; b += 2) begin
            for (int l = 2; l <= 8; l += 2) begin
                for (int k = 0; k < b + l; k++) begin
                    dual_step(pv(g_idx, k >= b), 1'b0, 1'b0,
                              (k >= b) ? "R3" : "R6");
                end
            end
        end

        // R7: odd blanking puts a rising DE on the second slot
        for (int k = 0; k < 3; k++) dual_step(pv(g_idx, 1'b0), 1'b0, 1'b0, "R7");
        dual_step(pv(g_idx, 1'b1), 1'b1, 1'b1, "R7");
        for (int k = 0; k < 6; k++) dual_step(pv(g_idx, 1'b1), 1'b1, 1'b0, "R8");
        for (int k = 0; k < 4; k++) dual_step(pv(g_idx, 1'b0), 1'b1, 1'b0, "R8");

        // R9: sleep clears the error and the phase; restart pairs fresh words
        wake = 1'b0;
        drive(pv(g_idx, 1'b1));
        chk_clear("R9");
        wake = 1'b1;
        t_idx = 0; ea = '0; eb = '0;
        for (int k = 0; k < 6; k++) dual_step(pv(g_idx, 1'b1), 1'b0, 1'b0, "R9");

        // R10: reset mid-pair (held word pending)
        dual_step(pv(g_idx, 1'b1), 1'b0, 1'b0, "R10");
        rst = 1'b1;
        drive(pv(g_idx, 1'b1));
        chk_clear("R10");
        rst = 1'b0;
        t_idx = 0; ea = '0; eb = '0;
        for (int k = 0; k < 4; k++) dual_step(pv(g_idx, 1'b1), 1'b0, 1'b0, "R10");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule